// File: doc/BRIEF.md
# AXI4-Lite Write Traffic Generator

This block is a small AXI4-Lite master that writes a fixed-length run of 32-bit words into memory whenever a start request arrives. The run targets consecutive word addresses from a base address set by a parameter. The data comes from a counter that is not cleared between runs. Each run therefore carries on the number sequence from where the previous run stopped. A downstream consumer can check this.

The start input is edge-detected. A request that lasts several cycles launches only one run, and a request that arrives while a run is in progress is dropped. Only the write address, write data and write response channels are used. Each transaction must get its response before the next one begins. Once the last response of a run has been accepted, a single-cycle done pulse is produced, suitable as an interrupt. Any response other than OKAY latches an error flag that only reset clears.

Top module: `axil_wrgen`

## Requirements
- R1: While and after an active-low synchronous reset, m_awvalid, m_wvalid, m_bready, done_o and err_o are 0, and m_wdata shows the seed value 0xAA000000.
- R2: A rising edge on start_i while idle launches exactly one run; start_i held high for two cycles still yields a single run.
- R3: A run consists of exactly four write transactions to addresses base+0x0, base+0x4, base+0x8 and base+0xC in that order, with a default base of 0x04000000.
- R4: Write data rises by one per transaction; the first run after reset writes 0xAA000000, 0xAA000001, 0xAA000002, 0xAA000003.
- R5: The data counter keeps its value between runs, so the second run writes 0xAA000004 through 0xAA000007.
- R6: m_awvalid stays high with m_awaddr stable until m_awready is seen, and m_wvalid stays high with m_wdata stable until m_wready is seen; the two channels complete independently.
- R7: A transaction's address and data are offered only after the previous transaction's response has been accepted, and m_bready is high only when neither m_awvalid nor m_wvalid is high.
- R8: done_o is high for exactly one cycle, the cycle right after the fourth response handshake (m_bvalid and m_bready both high) of a run.
- R9: A rising edge on start_i while a run is active is ignored; it neither adds writes nor adds a done pulse.
- R10: Every transaction uses m_wstrb = 4'b1111 and m_awprot = 3'b000.
- R11: A response with m_bresp not equal to 2'b00 (OKAY) sets err_o, which stays set through later OKAY runs until reset.
- R12: A reset during a run abandons it and returns the data counter to 0xAA000000 and the controller to idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Run request, acted on at its rising edge |
| m_awaddr | output | 32 | Write address |
| m_awprot | output | 3 | Write protection, always 0 |
| m_awvalid | output | 1 | Write address valid |
| m_awready | input | 1 | Write address ready |
| m_wdata | output | 32 | Write data, the running counter |
| m_wstrb | output | 4 | Byte strobes, always all ones |
| m_wvalid | output | 1 | Write data valid |
| m_wready | input | 1 | Write data ready |
| m_bresp | input | 2 | Write response code |
| m_bvalid | input | 1 | Write response valid |
| m_bready | output | 1 | Write response ready |
| done_o | output | 1 | One-cycle pulse when a run completes |
| err_o | output | 1 | Sticky flag for a non-OKAY response |

## Verification
The assertions check, on every cycle, the behaviours that hold locally in time. These are the valid/stable hold rules on both request channels, the constant strobe and protection values, the address staying inside the four-word window, the data stepping by one per data handshake, the single-cycle done pulse and the sticky error flag. Some behaviours span a whole run or several runs, and only the directed scenarios can show them. These are the exact count of writes per request, the address order and data values recorded by the bench's slave model, and the continuation of the sequence into the next run. The same holds for the dropping of a second start while busy and the return to the seed after a reset in the middle of a run.

// File: rtl/axil_wrgen_pkg.sv
package axil_wrgen_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_RESP = 2'd2
  } wr_state_e;

  localparam logic [1:0] RESP_OKAY = 2'b00;

endpackage

// File: rtl/wrgen_start_edge.sv
module wrgen_start_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic busy_i,
  output logic launch_o
);

  logic start_q;

  always_ff @(posedge clk) begin
    if (!rst_n) start_q <= 1'b0;
    else        start_q <= start_i;
  end

  // a rising edge counts only while the controller is idle
  assign launch_o = start_i & ~start_q & ~busy_i;

endmodule

// File: rtl/wrgen_seq.sv
module wrgen_seq #(
  parameter int                ADDR_W     = 32,
  parameter int                DATA_W     = 32,
  parameter int                NUM_WRITES = 4,
  parameter logic [ADDR_W-1:0] BASE_ADDR  = 32'h0400_0000,
  parameter logic [DATA_W-1:0] SEED       = 32'hAA00_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch_i,
  input  logic              w_fire_i,
  input  logic              b_fire_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o,
  output logic              last_o
);

  localparam int IDX_W = (NUM_WRITES > 1) ? $clog2(NUM_WRITES) : 1;
  localparam int SHIFT = $clog2(DATA_W / 8);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_WRITES - 1);

  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] data_q;

  function automatic logic [ADDR_W-1:0] slot_addr(input logic [IDX_W-1:0] idx);
    return BASE_ADDR + (ADDR_W'(idx) << SHIFT);
  endfunction

  function automatic logic [DATA_W-1:0] next_word(input logic [DATA_W-1:0] cur);
    return cur + DATA_W'(1);
  endfunction

  assign last_o = (idx_q == LAST_IDX);
  assign addr_o = slot_addr(idx_q);
  assign data_o = data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (launch_i) begin
      idx_q <= '0;
    end else if (b_fire_i) begin
      idx_q <= last_o ? '0 : idx_q + IDX_W'(1);
    end
  end

  // the data counter is cleared only by reset, never by a new run
  always_ff @(posedge clk) begin
    if (!rst_n)        data_q <= SEED;
    else if (w_fire_i) data_q <= next_word(data_q);
  end

endmodule

// File: rtl/wrgen_ctrl.sv
module wrgen_ctrl
  import axil_wrgen_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       launch_i,
  input  logic       last_i,
  input  logic       awready_i,
  input  logic       wready_i,
  input  logic       bvalid_i,
  input  logic [1:0] bresp_i,
  output logic       awvalid_o,
  output logic       wvalid_o,
  output logic       bready_o,
  output logic       aw_fire_o,
  output logic       w_fire_o,
  output logic       b_fire_o,
  output logic       busy_o,
  output logic       done_o,
  output logic       err_o
);

  wr_state_e state_q;
  logic      aw_pend_q, w_pend_q, done_q, err_q;
  logic      both_sent;

  assign awvalid_o = aw_pend_q;
  assign wvalid_o  = w_pend_q;
  assign bready_o  = (state_q == ST_RESP);
  assign aw_fire_o = aw_pend_q & awready_i;
  assign w_fire_o  = w_pend_q & wready_i;
  assign b_fire_o  = bready_o & bvalid_i;
  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = done_q;
  assign err_o     = err_q;

  assign both_sent = (!aw_pend_q || awready_i) && (!w_pend_q || wready_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      aw_pend_q <= 1'b0;
      w_pend_q  <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (launch_i) begin
            state_q   <= ST_XFER;
            aw_pend_q <= 1'b1;
            w_pend_q  <= 1'b1;
          end
        end
        ST_XFER: begin
          if (aw_fire_o) aw_pend_q <= 1'b0;
          if (w_fire_o)  w_pend_q  <= 1'b0;
          if (both_sent) state_q   <= ST_RESP;
        end
        ST_RESP: begin
          if (b_fire_o) begin
            if (last_i) begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
            end else begin
              state_q   <= ST_XFER;
              aw_pend_q <= 1'b1;
              w_pend_q  <= 1'b1;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                             err_q <= 1'b0;
    else if (b_fire_o && bresp_i != RESP_OKAY) err_q <= 1'b1;
  end

endmodule

// File: rtl/axil_wrgen.sv
module axil_wrgen #(
  parameter int                ADDR_W     = 32,
  parameter int                DATA_W     = 32,
  parameter int                NUM_WRITES = 4,
  parameter logic [ADDR_W-1:0] BASE_ADDR  = 32'h0400_0000,
  parameter logic [DATA_W-1:0] SEED       = 32'hAA00_0000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  output logic [ADDR_W-1:0]   m_awaddr,
  output logic [2:0]          m_awprot,
  output logic                m_awvalid,
  input  logic                m_awready,
  output logic [DATA_W-1:0]   m_wdata,
  output logic [DATA_W/8-1:0] m_wstrb,
  output logic                m_wvalid,
  input  logic                m_wready,
  input  logic [1:0]          m_bresp,
  input  logic                m_bvalid,
  output logic                m_bready,
  output logic                done_o,
  output logic                err_o
);

  logic launch, busy, last;
  logic aw_fire, w_fire, b_fire;

  assign m_awprot = 3'b000;
  assign m_wstrb  = '1;

  wrgen_start_edge u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .busy_i   (busy),
    .launch_o (launch)
  );

  wrgen_seq #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .NUM_WRITES (NUM_WRITES),
    .BASE_ADDR  (BASE_ADDR),
    .SEED       (SEED)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .launch_i (launch),
    .w_fire_i (w_fire),
    .b_fire_i (b_fire),
    .addr_o   (m_awaddr),
    .data_o   (m_wdata),
    .last_o   (last)
  );

  wrgen_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .launch_i  (launch),
    .last_i    (last),
    .awready_i (m_awready),
    .wready_i  (m_wready),
    .bvalid_i  (m_bvalid),
    .bresp_i   (m_bresp),
    .awvalid_o (m_awvalid),
    .wvalid_o  (m_wvalid),
    .bready_o  (m_bready),
    .aw_fire_o (aw_fire),
    .w_fire_o  (w_fire),
    .b_fire_o  (b_fire),
    .busy_o    (busy),
    .done_o    (done_o),
    .err_o     (err_o)
  );

endmodule

// File: rtl/axil_wrgen_chk.sv
module axil_wrgen_chk #(
  parameter int                ADDR_W     = 32,
  parameter int                DATA_W     = 32,
  parameter int                NUM_WRITES = 4,
  parameter logic [ADDR_W-1:0] BASE_ADDR  = 32'h0400_0000
) (
  input logic                clk,
  input logic                rst_n,
  input logic [ADDR_W-1:0]   awaddr,
  input logic [2:0]          awprot,
  input logic                awvalid,
  input logic                awready,
  input logic [DATA_W-1:0]   wdata,
  input logic [DATA_W/8-1:0] wstrb,
  input logic                wvalid,
  input logic                wready,
  input logic                bready,
  input logic                w_fire,
  input logic                b_fire,
  input logic                done,
  input logic                err
);

  localparam int BYTES = DATA_W / 8;
  localparam logic [ADDR_W:0] END_ADDR = {1'b0, BASE_ADDR} + (ADDR_W+1)'(NUM_WRITES * BYTES);

  a_r6_aw_hold: assert property (@(posedge clk) disable iff (!rst_n)
    awvalid && !awready |=> awvalid && $stable(awaddr));

  a_r6_w_hold: assert property (@(posedge clk) disable iff (!rst_n)
    wvalid && !wready |=> wvalid && $stable(wdata));

  a_r7_bready_gate: assert property (@(posedge clk) disable iff (!rst_n)
    bready |-> !awvalid && !wvalid);

  a_r10_strb: assert property (@(posedge clk) disable iff (!rst_n)
    wvalid |-> wstrb == {BYTES{1'b1}});

  a_r10_prot: assert property (@(posedge clk) disable iff (!rst_n)
    awvalid |-> awprot == 3'b000);

  a_r3_addr_window: assert property (@(posedge clk) disable iff (!rst_n)
    awvalid |-> ({1'b0, awaddr} >= {1'b0, BASE_ADDR}) && ({1'b0, awaddr} < END_ADDR)
                && (awaddr[1:0] == 2'b00));

  a_r4_data_step: assert property (@(posedge clk) disable iff (!rst_n)
    w_fire |=> wdata == $past(wdata) + DATA_W'(1));

  a_r5_data_kept: assert property (@(posedge clk) disable iff (!rst_n)
    !w_fire |=> $stable(wdata));

  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_done_cause: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(b_fire));

  a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

endmodule

bind axil_wrgen axil_wrgen_chk #(
  .ADDR_W     (ADDR_W),
  .DATA_W     (DATA_W),
  .NUM_WRITES (NUM_WRITES),
  .BASE_ADDR  (BASE_ADDR)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .awaddr  (m_awaddr),
  .awprot  (m_awprot),
  .awvalid (m_awvalid),
  .awready (m_awready),
  .wdata   (m_wdata),
  .wstrb   (m_wstrb),
  .wvalid  (m_wvalid),
  .wready  (m_wready),
  .bready  (m_bready),
  .w_fire  (w_fire),
  .b_fire  (b_fire),
  .done    (done_o),
  .err     (err_o)
);

// File: tb/axil_wrgen_test.sv
module axil_wrgen_test;

  localparam logic [31:0] BASE = 32'h0400_0000;
  localparam logic [31:0] SEED = 32'hAA00_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] m_awaddr;
  logic [2:0]  m_awprot;
  logic        m_awvalid;
  logic        m_awready = 1'b0;
  logic [31:0] m_wdata;
  logic [3:0]  m_wstrb;
  logic        m_wvalid;
  logic        m_wready = 1'b0;
  logic [1:0]  m_bresp = 2'b00;
  logic        m_bvalid = 1'b0;
  logic        m_bready;
  logic        done_o, err_o;

  axil_wrgen uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .m_awaddr(m_awaddr), .m_awprot(m_awprot), .m_awvalid(m_awvalid), .m_awready(m_awready),
    .m_wdata(m_wdata), .m_wstrb(m_wstrb), .m_wvalid(m_wvalid), .m_wready(m_wready),
    .m_bresp(m_bresp), .m_bvalid(m_bvalid), .m_bready(m_bready),
    .done_o(done_o), .err_o(err_o)
  );

  always #4 clk = ~clk;

  int checks = 0, fails = 0;
  int aw_dly = 0, w_dly = 0;
  logic [1:0] resp_cfg = 2'b00;
  logic [31:0] exp_next = SEED;

  // slave model and monitor state
  logic [31:0] log_addr [64];
  logic [31:0] log_data [64];
  int nlog = 0, cyc = 0, done_cnt = 0, done_cyc = 0, last_b_cyc = 0;
  int v_hold = 0, v_order = 0, v_strb = 0;
  int awc = 0, wc = 0;
  bit got_aw = 0, got_w = 0, awv_wait = 0, wv_wait = 0;
  logic [31:0] cur_addr, cur_data, awv_addr, wv_data;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (rst_n) begin
        if (awv_wait && (!m_awvalid || m_awaddr !== awv_addr)) v_hold++;
        if (wv_wait && (!m_wvalid || m_wdata !== wv_data)) v_hold++;
        if ((m_awvalid && got_aw) || (m_wvalid && got_w)) v_order++;
        if (m_bready && (m_awvalid || m_wvalid)) v_order++;
        if (m_wvalid && m_wstrb !== 4'hF) v_strb++;
        if (m_awvalid && m_awprot !== 3'b000) v_strb++;
        if (done_o) begin done_cnt++; done_cyc = cyc; end
      end
      awv_wait = rst_n && m_awvalid && !m_awready; awv_addr = m_awaddr;
      wv_wait  = rst_n && m_wvalid && !m_wready;   wv_data  = m_wdata;
      if (!rst_n) begin
        m_awready <= 1'b0; m_wready <= 1'b0; m_bvalid <= 1'b0;
        got_aw = 0; got_w = 0; awc = 0; wc = 0;
      end else begin
        if (m_awvalid && m_awready) begin
          got_aw = 1; cur_addr = m_awaddr; m_awready <= 1'b0; awc = 0;
        end else if (m_awvalid && !got_aw && !m_awready) begin
          if (awc >= aw_dly) m_awready <= 1'b1; else awc++;
        end
        if (m_wvalid && m_wready) begin
          got_w = 1; cur_data = m_wdata; m_wready <= 1'b0; wc = 0;
        end else if (m_wvalid && !got_w && !m_wready) begin
          if (wc >= w_dly) m_wready <= 1'b1; else wc++;
        end
        if (m_bvalid && m_bready) begin
          m_bvalid <= 1'b0;
          if (nlog < 64) begin log_addr[nlog] = cur_addr; log_data[nlog] = cur_data; end
          nlog++; last_b_cyc = cyc; got_aw = 0; got_w = 0;
        end else if (got_aw && got_w && !m_bvalid) begin
          m_bvalid <= 1'b1; m_bresp <= resp_cfg;
        end
      end
    end
  end

  task automatic t_idle_outputs(input string req);
    chk({req, " awvalid"}, 32'(m_awvalid), 32'd0);
    chk({req, " wvalid"},  32'(m_wvalid),  32'd0);
    chk({req, " bready"},  32'(m_bready),  32'd0);
    chk({req, " done"},    32'(done_o),    32'd0);
    chk({req, " err"},     32'(err_o),     32'd0);
    chk({req, " wdata seed"}, m_wdata, SEED);
  endtask

  // one run: start held 'hold' cycles, optional extra start 'extra' cycles later
  task automatic t_run(input string req, input int hold, input int extra,
                       input int ad, input int wd, input logic [1:0] rsp);
    int n0, d0, wait_cnt;
    aw_dly = ad; w_dly = wd; resp_cfg = rsp;
    n0 = nlog; d0 = done_cnt;
    @(negedge clk); start_i = 1'b1;
    repeat (hold) @(negedge clk);
    start_i = 1'b0;
    if (extra > 0) begin
      repeat (extra) @(negedge clk);
      start_i = 1'b1; @(negedge clk); start_i = 1'b0;
    end
    wait_cnt = 0;
    while (done_cnt == d0 && wait_cnt < 400) begin @(negedge clk); wait_cnt++; end
    repeat (30) @(negedge clk);
    chk({req, " R3 writes per run"}, 32'(nlog - n0), 32'd4);
    for (int i = 0; i < 4; i++) begin
      if (n0 + i < 64) begin
        chk({req, " R3 address"}, log_addr[n0 + i], BASE + 32'(4 * i));
        chk({req, " R4/R5 data"}, log_data[n0 + i], exp_next + 32'(i));
      end
    end
    chk({req, " R8 done pulses"}, 32'(done_cnt - d0), 32'd1);
    chk({req, " R8 done timing"}, 32'(done_cyc), 32'(last_b_cyc + 1));
    exp_next = exp_next + 32'd4;
  endtask

  task automatic t_reset_check;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    t_idle_outputs("R1 in reset");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_idle_outputs("R1 after reset");
  endtask

  task automatic t_first_run;
    t_run("R4 first run", 1, 0, 0, 0, 2'b00);
  endtask

  task automatic t_second_run_long_start;
    t_run("R2 R5 two-cycle start, aw stall", 2, 0, 3, 0, 2'b00);
  endtask

  task automatic t_w_stall;
    t_run("R6 w stall", 1, 0, 0, 4, 2'b00);
  endtask

  task automatic t_busy_start;
    t_run("R9 start while busy", 1, 6, 3, 2, 2'b00);
  endtask

  task automatic t_error_sticky;
    t_run("R11 slverr run", 1, 0, 1, 1, 2'b10);
    chk("R11 err set", 32'(err_o), 32'd1);
    t_run("R11 okay run", 1, 0, 0, 0, 2'b00);
    chk("R11 err kept", 32'(err_o), 32'd1);
  endtask

  task automatic t_reset_mid_run;
    aw_dly = 2; w_dly = 2; resp_cfg = 2'b00;
    @(negedge clk); start_i = 1'b1; @(negedge clk); start_i = 1'b0;
    repeat (7) @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_idle_outputs("R12 after mid-run reset");
    exp_next = SEED;
    t_run("R12 run after reset", 1, 0, 0, 0, 2'b00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_reset_check();
    t_first_run();
    t_second_run_long_start();
    t_w_stall();
    t_busy_start();
    t_error_sticky();
    t_reset_mid_run();
    chk("R6 valid hold violations", 32'(v_hold), 32'd0);
    chk("R7 ordering violations", 32'(v_order), 32'd0);
    chk("R10 strobe/prot violations", 32'(v_strb), 32'd0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule